// File: doc/BRIEF.md
# Top-Three Minimum SAD Tracker

This block sits at the end of a block-matching datapath and keeps a running record of the three best candidates it has seen. A candidate is a sum-of-absolute-differences score together with a tag, typically a packed motion vector. The three stored entries are always held in nondecreasing score order. Each entry carries the tag that arrived with its score and a flag that shows whether a real candidate has filled it.

Every accepted candidate goes to three comparators at the same time. Each comparator checks whether the candidate is strictly less than one stored entry. The three less-than bits alone decide where the candidate goes. The entry at that position and every entry below it move down one place, and the entry that falls off the end is discarded. No sorting network is used, and an update takes one clock cycle.

The candidate input uses a valid/ready handshake. A candidate is taken on a rising edge where `cand_valid` and `cand_ready` are both high. `cand_ready` drops only while `clr` is high, and the producer must then hold its candidate until ready returns. With no clear pending, the block accepts one candidate every cycle, back to back. `clr` is a plain synchronous control that starts a new search.

Top module: `min3_tracker`

## Requirements
- R1: While `rst_n` is low, and after it is released, every slot reads score 16'hFFFF, tag 0 and valid flag 0.
- R2: While `clr` is high, `cand_ready` is 0. On the next edge every slot becomes score 16'hFFFF, tag 0 and flag 0, whatever `cand_valid` is.
- R3: An accepted candidate whose score is below slot 0 (slot 0 holds the smallest score) leaves the slots as {candidate, old slot 0, old slot 1}.
- R4: An accepted candidate with old slot 0 <= score < old slot 1 leaves the slots as {old slot 0, candidate, old slot 1}.
- R5: An accepted candidate with old slot 1 <= score < old slot 2 replaces only slot 2.
- R6: An accepted candidate whose score is >= old slot 2 changes nothing. A tie therefore keeps the earlier entry, and a score of 16'hFFFF is never stored.
- R7: On an edge with no accepted candidate and `clr` low, no slot changes.
- R8: Scores read out of slots 0, 1 and 2 (low bits of `min_sad` first) are always nondecreasing. A slot's flag is 1 only if the flag of the slot above it is 1. A slot written with a candidate takes that candidate's tag and sets its flag to 1, and a moved entry keeps its own tag and flag.
- R9: The result of an accepted candidate appears on the outputs right after the accepting edge, and candidates presented on consecutive cycles are all taken in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all slots |
| cand_valid | input | 1 | Candidate present |
| cand_ready | output | 1 | Block can take a candidate (low during clear) |
| cand_sad | input | 16 | Candidate score |
| cand_tag | input | 8 | Candidate tag |
| min_sad | output | 48 | Slot scores, slot 0 in bits 15:0 |
| min_tag | output | 24 | Slot tags, slot 0 in bits 7:0 |
| min_vld | output | 3 | Slot filled flags, bit i for slot i |

## Verification
The slot registers drive the outputs directly. A wrong shift, a misplaced insert or a lost tag therefore shows up in full on the cycle after the edge that accepted the candidate, and it stays visible until a later insert overwrites it. The bench compares all three scores, tags and flags after every single candidate. It does this across every four-candidate sequence drawn from a small score set that includes ties and the all-ones score, so an error in any comparator or shift path shows up at the first sequence that reaches it.

// File: rtl/min3_pkg.sv
package min3_pkg;
  // Action applied to one slot register on a clock edge
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_CAND  = 2'd1,
    ACT_UPPER = 2'd2,
    ACT_EMPTY = 2'd3
  } slot_act_e;
endpackage

// File: rtl/min3_cmp.sv
module min3_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         lt
);
  // Less-than bit, playing the role of a subtractor sign output
  logic [W:0] diff;
  assign diff = {1'b0, a} - {1'b0, b};
  assign lt   = diff[W];
endmodule

// File: rtl/min3_route.sv
module min3_route
  import min3_pkg::*;
#(
  parameter int SLOTS = 3
) (
  input  logic             clr,
  input  logic             accept,
  input  logic [SLOTS-1:0] lt,
  output slot_act_e        act [SLOTS]
);
  // Because the slots are sorted, lt is a thermometer code. The insert
  // point is the first slot whose lt bit is set.
  for (genvar i = 0; i < SLOTS; i++) begin : g_act
    if (i == 0) begin : g_top
      always_comb begin
        if (clr)          act[i] = ACT_EMPTY;
        else if (!accept) act[i] = ACT_HOLD;
        else if (lt[i])   act[i] = ACT_CAND;
        else              act[i] = ACT_HOLD;
      end
    end else begin : g_low
      always_comb begin
        if (clr)                     act[i] = ACT_EMPTY;
        else if (!accept)            act[i] = ACT_HOLD;
        else if (lt[i-1])            act[i] = ACT_UPPER;
        else if (lt[i])              act[i] = ACT_CAND;
        else                         act[i] = ACT_HOLD;
      end
    end
  end
endmodule

// File: rtl/min3_slot.sv
module min3_slot
  import min3_pkg::*;
#(
  parameter int SAD_W = 16,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  slot_act_e        act,
  input  logic [SAD_W-1:0] cand_sad,
  input  logic [TAG_W-1:0] cand_tag,
  input  logic [SAD_W-1:0] up_sad,
  input  logic [TAG_W-1:0] up_tag,
  input  logic             up_vld,
  output logic [SAD_W-1:0] q_sad,
  output logic [TAG_W-1:0] q_tag,
  output logic             q_vld
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_sad <= '1;
      q_tag <= '0;
      q_vld <= 1'b0;
    end else begin
      unique case (act)
        ACT_CAND: begin
          q_sad <= cand_sad;
          q_tag <= cand_tag;
          q_vld <= 1'b1;
        end
        ACT_UPPER: begin
          q_sad <= up_sad;
          q_tag <= up_tag;
          q_vld <= up_vld;
        end
        ACT_EMPTY: begin
          q_sad <= '1;
          q_tag <= '0;
          q_vld <= 1'b0;
        end
        default: begin
          q_sad <= q_sad;
          q_tag <= q_tag;
          q_vld <= q_vld;
        end
      endcase
    end
  end
endmodule

// File: rtl/min3_tracker.sv
module min3_tracker
  import min3_pkg::*;
#(
  parameter int SAD_W = 16,
  parameter int TAG_W = 8,
  parameter int SLOTS = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   cand_valid,
  output logic                   cand_ready,
  input  logic [SAD_W-1:0]       cand_sad,
  input  logic [TAG_W-1:0]       cand_tag,
  output logic [SLOTS*SAD_W-1:0] min_sad,
  output logic [SLOTS*TAG_W-1:0] min_tag,
  output logic [SLOTS-1:0]       min_vld
);
  logic             accept;
  logic [SLOTS-1:0] lt;
  slot_act_e        act   [SLOTS];
  logic [SAD_W-1:0] q_sad [SLOTS];
  logic [TAG_W-1:0] q_tag [SLOTS];
  logic             q_vld [SLOTS];

  assign cand_ready = ~clr;
  assign accept     = cand_valid & cand_ready;

  min3_route #(.SLOTS(SLOTS)) u_route (
    .clr    (clr),
    .accept (accept),
    .lt     (lt),
    .act    (act)
  );

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [SAD_W-1:0] up_sad;
    logic [TAG_W-1:0] up_tag;
    logic             up_vld;

    if (i == 0) begin : g_head
      assign up_sad = '1;
      assign up_tag = '0;
      assign up_vld = 1'b0;
    end else begin : g_chain
      assign up_sad = q_sad[i-1];
      assign up_tag = q_tag[i-1];
      assign up_vld = q_vld[i-1];
    end

    min3_cmp #(.W(SAD_W)) u_cmp (
      .a  (cand_sad),
      .b  (q_sad[i]),
      .lt (lt[i])
    );

    min3_slot #(.SAD_W(SAD_W), .TAG_W(TAG_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .act      (act[i]),
      .cand_sad (cand_sad),
      .cand_tag (cand_tag),
      .up_sad   (up_sad),
      .up_tag   (up_tag),
      .up_vld   (up_vld),
      .q_sad    (q_sad[i]),
      .q_tag    (q_tag[i]),
      .q_vld    (q_vld[i])
    );

    assign min_sad[i*SAD_W +: SAD_W] = q_sad[i];
    assign min_tag[i*TAG_W +: TAG_W] = q_tag[i];
    assign min_vld[i]                = q_vld[i];
  end
endmodule

// File: rtl/min3_tracker_chk.sv
module min3_tracker_chk #(
  parameter int SAD_W = 16,
  parameter int TAG_W = 8,
  parameter int SLOTS = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   clr,
  input logic                   cand_valid,
  input logic                   cand_ready,
  input logic [SAD_W-1:0]       cand_sad,
  input logic [TAG_W-1:0]       cand_tag,
  input logic [SLOTS*SAD_W-1:0] min_sad,
  input logic [SLOTS*TAG_W-1:0] min_tag,
  input logic [SLOTS-1:0]       min_vld
);
  localparam int LAST = SLOTS - 1;
  logic take;
  assign take = cand_valid && cand_ready;

  assert_clear_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !cand_ready);
  assert_clear_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (min_vld == '0) && (min_sad == '1) && (min_tag == '0));
  assert_head_insert_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cand_sad < min_sad[0 +: SAD_W]) |=>
      (min_sad[0 +: SAD_W] == $past(cand_sad)) && (min_tag[0 +: TAG_W] == $past(cand_tag))
      && (min_sad[SAD_W +: SAD_W] == $past(min_sad[0 +: SAD_W])));
  assert_tail_replace_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cand_sad >= min_sad[(LAST-1)*SAD_W +: SAD_W] && cand_sad < min_sad[LAST*SAD_W +: SAD_W]) |=>
      (min_sad[LAST*SAD_W +: SAD_W] == $past(cand_sad))
      && $stable(min_sad[0 +: LAST*SAD_W]) && $stable(min_tag[0 +: LAST*TAG_W]));
  assert_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cand_sad >= min_sad[LAST*SAD_W +: SAD_W]) |=>
      $stable(min_sad) && $stable(min_tag) && $stable(min_vld));
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !clr) |=> $stable(min_sad) && $stable(min_tag) && $stable(min_vld));

  for (genvar i = 1; i < SLOTS; i++) begin : g_ord
    assert_sorted_R8: assert property (@(posedge clk) disable iff (!rst_n)
      min_sad[(i-1)*SAD_W +: SAD_W] <= min_sad[i*SAD_W +: SAD_W]);
    assert_flag_prefix_R8: assert property (@(posedge clk) disable iff (!rst_n)
      min_vld[i] |-> min_vld[i-1]);
  end
endmodule

bind min3_tracker min3_tracker_chk #(.SAD_W(SAD_W), .TAG_W(TAG_W), .SLOTS(SLOTS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr        (clr),
  .cand_valid (cand_valid),
  .cand_ready (cand_ready),
  .cand_sad   (cand_sad),
  .cand_tag   (cand_tag),
  .min_sad    (min_sad),
  .min_tag    (min_tag),
  .min_vld    (min_vld)
);

// File: tb/min3_tracker_bench.sv
module min3_tracker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 16;
  localparam int TW = 8;
  localparam int NS = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr = 1'b0;
  logic          cand_valid = 1'b0;
  logic          cand_ready;
  logic [SW-1:0] cand_sad = '0;
  logic [TW-1:0] cand_tag = '0;
  logic [NS*SW-1:0] min_sad;
  logic [NS*TW-1:0] min_tag;
  logic [NS-1:0]    min_vld;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [SW-1:0] m_sad [NS];
  logic [TW-1:0] m_tag [NS];
  logic          m_vld [NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  min3_tracker #(.SAD_W(SW), .TAG_W(TW), .SLOTS(NS)) u_min3_tracker (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cand_valid(cand_valid),
    .cand_ready(cand_ready), .cand_sad(cand_sad), .cand_tag(cand_tag),
    .min_sad(min_sad), .min_tag(min_tag), .min_vld(min_vld)
  );

  task automatic model_empty();
    for (int i = 0; i < NS; i++) begin
      m_sad[i] = '1; m_tag[i] = '0; m_vld[i] = 1'b0;
    end
  endtask

  // Returns the insert position; NS means rejected
  function automatic int model_insert(logic [SW-1:0] s, logic [TW-1:0] t);
    int pos = NS;
    for (int i = NS-1; i >= 0; i--) if (s < m_sad[i]) pos = i;
    if (pos < NS) begin
      for (int i = NS-1; i > pos; i--) begin
        m_sad[i] = m_sad[i-1]; m_tag[i] = m_tag[i-1]; m_vld[i] = m_vld[i-1];
      end
      m_sad[pos] = s; m_tag[pos] = t; m_vld[pos] = 1'b1;
    end
    return pos;
  endfunction

  task automatic compare(string req);
    for (int i = 0; i < NS; i++) begin
      checks++;
      if (min_sad[i*SW +: SW] !== m_sad[i] || min_tag[i*TW +: TW] !== m_tag[i]
          || min_vld[i] !== m_vld[i]) begin
        failures++;
        $display("FAIL %s slot %0d: actual sad=%h tag=%h vld=%b expected sad=%h tag=%h vld=%b",
                 req, i, min_sad[i*SW +: SW], min_tag[i*TW +: TW], min_vld[i],
                 m_sad[i], m_tag[i], m_vld[i]);
      end
    end
  endtask

  function automatic string case_req(int pos);
    case (pos)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic push(logic [SW-1:0] s, logic [TW-1:0] t);
    int pos;
    @(negedge clk);
    cand_valid = 1'b1; cand_sad = s; cand_tag = t;
    @(negedge clk);
    cand_valid = 1'b0;
    pos = model_insert(s, t);
    compare(case_req(pos));
  endtask

  task automatic do_clear(bit with_valid);
    @(negedge clk);
    clr = 1'b1; cand_valid = with_valid; cand_sad = '0; cand_tag = 8'h5A;
    #1;
    checks++;
    if (cand_ready !== 1'b0) begin
      failures++;
      $display("FAIL R2 ready during clear: actual %b expected 0", cand_ready);
    end
    @(negedge clk);
    clr = 1'b0; cand_valid = 1'b0;
    model_empty();
    compare("R2");
  endtask

  function automatic logic [SW-1:0] vmap(int k);
    return (k == 4) ? 16'hFFFF : SW'(k * 3 + 2);
  endfunction

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual running expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_empty();
    #(CLK_PERIOD * 2 + 1);
    compare("R1");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");
    checks++;
    if (cand_ready !== 1'b1) begin
      failures++;
      $display("FAIL R9 ready idle: actual %b expected 1", cand_ready);
    end

    // Exhaustive four-candidate sequences over a five-value set with ties
    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 5; b++)
        for (int c = 0; c < 5; c++)
          for (int d = 0; d < 5; d++) begin
            do_clear(1'b0);
            push(vmap(a), 8'(a*5 + 1));
            push(vmap(b), 8'(b*5 + 2));
            push(vmap(c), 8'(c*5 + 3));
            push(vmap(d), 8'(d*5 + 4));
          end

    // R7: valid low with a small score presented: nothing moves
    @(negedge clk);
    cand_valid = 1'b0; cand_sad = 16'h0000; cand_tag = 8'hEE;
    repeat (3) @(negedge clk);
    compare("R7");

    // R9: back-to-back candidates, checked after every edge
    @(negedge clk);
    model_empty();
    for (int k = 0; k < 6; k++) begin
      cand_valid = 1'b1;
      cand_sad = SW'(100 - k * 7 + (k % 2) * 30);
      cand_tag = 8'(8'h80 + k);
      @(negedge clk);
      void'(model_insert(cand_sad, cand_tag));
      compare("R9");
    end
    cand_valid = 1'b0;

    // R2: clear wins over a presented candidate
    do_clear(1'b1);
    push(16'h0010, 8'h11);
    compare("R8");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule